// File: doc/BRIEF.md
# TLB Maintenance Register File

This block is the register interface software uses to maintain a translation lookaside buffer. It holds the entry storage (a tag word, a data word and an 8-bit translation ID per entry) and five software-visible registers: an index register that picks the entry, a high window onto the selected entry's tag word, a low window onto its data word, a process ID register and a zone protection register. A sixth address is a search trigger. Writing it hands a page number to a separate translation datapath through a lookup port, and the result lands in the index register.

Accesses use a simple request/ready register bus. The master holds request, write enable, address and write data stable until it sees a one-cycle ready pulse, and then drops the request. A two-bit access level input limits what software may do. Level 0 disables the interface. Bit 0 allows reads of the windows, the process ID and the zone register. Levels 2 and 3 allow writes to the process ID, the zone register and the search trigger.

Top module: `tlb_mgmt_regs`

## Requirements
- R1: After reset the index, process ID and zone registers read 0, bus_ready is low and bus_rdata is 0.
- R2: The windows address the entry given by the low log2(ENTRIES) bits of the index register (the low 8 bits at the default of 256 entries). Higher index bits do not affect the selection.
- R3: A write to offset 0 stores the write data as the selected entry's data word. A write to offset 1 stores it as the tag word and copies the low 8 bits of the process ID register into that entry's translation ID. Reads of those offsets return the stored words.
- R4: A read of offset 1 also loads the entry's translation ID, zero-extended, into the process ID register. A read of offset 0 leaves the process ID unchanged.
- R5: A write to offset 5 starts one lookup with lk_vpn = wdata[31:10]. On a hit the index register becomes the hit index, zero-extended. On a miss bit 31 of the index register is set and bits 30:0 keep their value.
- R6: At access level 0 every access is ignored: nothing is stored, no lookup starts, and reads return 0.
- R7: Reads of offsets 0, 1, 3 and 4 return 0 and have no side effect unless bit 0 of the access level is 1. The index register (offset 2) reads at any nonzero level. Offset 5 and offsets 6 and 7 always read 0.
- R8: Writes to offsets 3, 4 and 5 are dropped unless the access level is 2 or 3. Writes to offsets 0, 1 and 2 need only a nonzero level.
- R9: bus_ready is a one-cycle pulse. Register accesses answer in the cycle after acceptance and window reads one cycle later. A search keeps bus_ready low until lk_done returns, and bus_ready rises in the same cycle the index register shows the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_level | input | 2 | Access level configuration |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle completion pulse |
| lk_req | output | 1 | One-cycle lookup start pulse |
| lk_vpn | output | 22 | Page number to look up |
| lk_pid | output | 8 | Current process ID for the lookup |
| lk_zone | output | 32 | Zone protection word for the lookup |
| lk_done | input | 1 | Lookup finished |
| lk_hit | input | 1 | Lookup found a matching entry |
| lk_idx | input | 8 | Index of the matching entry |

## Verification
Every cycle, the assertions check the single-cycle ready pulse and the silence of bus_ready during a search. They also check that a hit copies the returned index, that a miss sets only the top index bit, that a lookup starts only at a write-enabled level, and that level-0 reads return zero. Only the bench scenarios show the data path through the entry storage: tag, data and translation-ID round trips, the swap of the translation ID into the process ID, the entry selection from the low index bits, and the dropped writes, which can be seen only by reading the registers back later at a higher level.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  typedef enum logic [2:0] {
    OFF_LO   = 3'd0,
    OFF_HI   = 3'd1,
    OFF_IDX  = 3'd2,
    OFF_PID  = 3'd3,
    OFF_ZONE = 3'd4,
    OFF_SRCH = 3'd5
  } reg_off_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WIN,
    ST_SRCH,
    ST_RESP
  } seq_st_e;
endpackage

// File: rtl/tlbm_entry_store.sv
module tlbm_entry_store #(
  parameter int ENTRIES = 256,
  parameter int WORD_W  = 32,
  parameter int TID_W   = 8,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic [AW-1:0]              addr,
  input  logic [1:0]                 bank_we,
  input  logic [WORD_W-1:0]          wdata,
  input  logic [TID_W-1:0]           tid_in,
  output logic [1:0][WORD_W-1:0]     bank_q,
  output logic [TID_W-1:0]           tid_q
);
  // bank 0 holds data words, bank 1 holds tag words
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] mem [ENTRIES];
    logic [WORD_W-1:0] q_r;
    always_ff @(posedge clk) begin
      if (bank_we[b]) mem[addr] <= wdata;
      q_r <= mem[addr];
    end
    assign bank_q[b] = q_r;
  end

  logic [TID_W-1:0] tid_mem [ENTRIES];
  always_ff @(posedge clk) begin
    if (bank_we[1]) tid_mem[addr] <= tid_in;
    tid_q <= tid_mem[addr];
  end
endmodule

// File: rtl/tlbm_access_gate.sv
module tlbm_access_gate
  import tlbm_pkg::*;
(
  input  logic [1:0] acc_level,
  input  logic [2:0] off,
  input  logic       we,
  output logic       allow
);
  always_comb begin
    allow = 1'b0;
    if (acc_level != 2'd0) begin
      if (we) begin
        case (off)
          OFF_LO, OFF_HI, OFF_IDX:   allow = 1'b1;
          OFF_PID, OFF_ZONE, OFF_SRCH: allow = acc_level[1];
          default:                   allow = 1'b0;
        endcase
      end else begin
        case (off)
          OFF_LO, OFF_HI, OFF_PID, OFF_ZONE: allow = acc_level[0];
          OFF_IDX:                           allow = 1'b1;
          default:                           allow = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tlb_mgmt_regs.sv
module tlb_mgmt_regs
  import tlbm_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int DATA_W  = 32,
  parameter int PID_W   = 8,
  parameter int VPN_LSB = 10,
  parameter int AW      = $clog2(ENTRIES),
  parameter int VPN_W   = DATA_W - VPN_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        acc_level,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              lk_req,
  output logic [VPN_W-1:0]  lk_vpn,
  output logic [PID_W-1:0]  lk_pid,
  output logic [DATA_W-1:0] lk_zone,
  input  logic              lk_done,
  input  logic              lk_hit,
  input  logic [AW-1:0]     lk_idx
);
  seq_st_e                 state;
  logic [DATA_W-1:0]       idx_r, pid_r, zone_r;
  logic                    hi_sel_r;
  logic                    allow, accept;
  logic [1:0]              bank_we;
  logic [1:0][DATA_W-1:0]  bank_q;
  logic [PID_W-1:0]        tid_q;

  tlbm_access_gate u_gate (
    .acc_level (acc_level),
    .off       (bus_addr),
    .we        (bus_we),
    .allow     (allow)
  );

  assign accept     = (state == ST_IDLE) && bus_req;
  assign bank_we[0] = accept && allow && bus_we && (bus_addr == OFF_LO);
  assign bank_we[1] = accept && allow && bus_we && (bus_addr == OFF_HI);

  tlbm_entry_store #(
    .ENTRIES (ENTRIES),
    .WORD_W  (DATA_W),
    .TID_W   (PID_W),
    .AW      (AW)
  ) u_store (
    .clk     (clk),
    .addr    (idx_r[AW-1:0]),
    .bank_we (bank_we),
    .wdata   (bus_wdata),
    .tid_in  (pid_r[PID_W-1:0]),
    .bank_q  (bank_q),
    .tid_q   (tid_q)
  );

  assign lk_pid  = pid_r[PID_W-1:0];
  assign lk_zone = zone_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx_r     <= '0;
      pid_r     <= '0;
      zone_r    <= '0;
      hi_sel_r  <= 1'b0;
      bus_rdata <= '0;
      bus_ready <= 1'b0;
      lk_req    <= 1'b0;
      lk_vpn    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          bus_ready <= 1'b0;
          lk_req    <= 1'b0;
          if (bus_req) begin
            bus_rdata <= '0;
            hi_sel_r  <= (bus_addr == OFF_HI);
            state     <= ST_RESP;
            bus_ready <= 1'b1;
            if (allow && bus_we) begin
              case (bus_addr)
                OFF_IDX:  idx_r  <= bus_wdata;
                OFF_PID:  pid_r  <= bus_wdata;
                OFF_ZONE: zone_r <= bus_wdata;
                OFF_SRCH: begin
                  lk_req    <= 1'b1;
                  lk_vpn    <= bus_wdata[DATA_W-1:VPN_LSB];
                  state     <= ST_SRCH;
                  bus_ready <= 1'b0;
                end
                default: ;
              endcase
            end else if (allow) begin
              case (bus_addr)
                OFF_LO, OFF_HI: begin
                  state     <= ST_WIN;
                  bus_ready <= 1'b0;
                end
                OFF_IDX:  bus_rdata <= idx_r;
                OFF_PID:  bus_rdata <= pid_r;
                OFF_ZONE: bus_rdata <= zone_r;
                default:  bus_rdata <= '0;
              endcase
            end
          end
        end
        ST_WIN: begin
          bus_rdata <= bank_q[hi_sel_r];
          if (hi_sel_r) pid_r <= DATA_W'(tid_q);
          bus_ready <= 1'b1;
          state     <= ST_RESP;
        end
        ST_SRCH: begin
          lk_req <= 1'b0;
          if (lk_done) begin
            if (lk_hit) idx_r <= DATA_W'(lk_idx);
            else        idx_r[DATA_W-1] <= 1'b1;
            bus_ready <= 1'b1;
            state     <= ST_RESP;
          end
        end
        default: begin
          bus_ready <= 1'b0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready);

  // R9: no completion while a lookup is outstanding
  p_quiet_search_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SRCH) |-> !bus_ready);

  // R5: a hit copies the returned index and completes
  p_hit_index_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SRCH && lk_done && lk_hit) |=>
      (idx_r == DATA_W'($past(lk_idx)) && bus_ready));

  // R5: a miss sets only the top index bit
  p_miss_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SRCH && lk_done && !lk_hit) |=>
      (idx_r[DATA_W-1] && idx_r[DATA_W-2:0] == $past(idx_r[DATA_W-2:0])));

  // R8: a lookup starts only at a write-enabled level
  p_lookup_level_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(lk_req) |-> $past(acc_level[1]));

  // R6: level 0 reads answer with zero
  p_level0_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && bus_req && !bus_we && acc_level == 2'd0) |=>
      (bus_rdata == '0 && bus_ready));
endmodule

// File: tb/tlb_mgmt_regs_tb.sv
module tlb_mgmt_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  acc_level = 2'd3;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        lk_req;
  logic [21:0] lk_vpn;
  logic [7:0]  lk_pid;
  logic [31:0] lk_zone;
  logic        lk_done = 1'b0, lk_hit = 1'b0;
  logic [7:0]  lk_idx = '0;

  int errs = 0, checks = 0;
  int mdl_delay = 2;
  logic mdl_hit = 1'b0;
  logic [7:0] mdl_idx = '0;
  int lk_count = 0;
  logic [21:0] seen_vpn = '0;

  always #10 clk = ~clk;

  tlb_mgmt_regs u_dut (
    .clk(clk), .rst(rst), .acc_level(acc_level),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_zone(lk_zone),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_idx(lk_idx)
  );

  // lookup datapath model
  initial begin
    forever begin
      @(negedge clk);
      if (lk_req) begin
        lk_count++;
        seen_vpn = lk_vpn;
        repeat (mdl_delay) @(negedge clk);
        lk_done = 1'b1; lk_hit = mdl_hit; lk_idx = mdl_idx;
        @(negedge clk);
        lk_done = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [2:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int cyc);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!bus_ready && cyc < 1000);
    rd = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] rd; int cyc;
    xfer(1'b1, a, d, rd, cyc);
  endtask

  task automatic rdr(input logic [2:0] a, output logic [31:0] rd);
    int cyc;
    xfer(1'b0, a, 32'h0, rd, cyc);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 ready after reset", {31'b0, bus_ready}, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rdr(3'd2, v); check("R1 index reset", v, 32'h0);
    rdr(3'd3, v); check("R1 pid reset", v, 32'h0);
    rdr(3'd4, v); check("R1 zone reset", v, 32'h0);
  endtask

  task automatic t_windows;
    logic [31:0] v; int cyc;
    wr(3'd3, 32'h0000_015A);
    wr(3'd2, 32'd5);
    wr(3'd1, 32'hABCD_0040);
    wr(3'd0, 32'h1234_5678);
    wr(3'd3, 32'h0000_0007);
    xfer(1'b0, 3'd1, 32'h0, v, cyc);
    check("R3 tag readback", v, 32'hABCD_0040);
    check("R9 window read latency", cyc, 2);
    rdr(3'd3, v); check("R4 pid loaded from tid", v, 32'h0000_005A);
    wr(3'd3, 32'h0000_0033);
    xfer(1'b0, 3'd0, 32'h0, v, cyc);
    check("R3 data readback", v, 32'h1234_5678);
    rdr(3'd3, v); check("R4 low read keeps pid", v, 32'h0000_0033);
    xfer(1'b0, 3'd2, 32'h0, v, cyc);
    check("R9 register read latency", cyc, 1);
  endtask

  task automatic t_index_select;
    logic [31:0] v;
    wr(3'd2, 32'd6);
    wr(3'd3, 32'h0000_0011);
    wr(3'd1, 32'h0000_0400);
    wr(3'd0, 32'hCAFE_0000);
    wr(3'd2, 32'hFFFF_FF05);
    rdr(3'd0, v); check("R2 upper index bits ignored", v, 32'h1234_5678);
    wr(3'd2, 32'h0000_0106);
    rdr(3'd0, v); check("R2 entry 6 data", v, 32'hCAFE_0000);
    rdr(3'd1, v); check("R2 entry 6 tag", v, 32'h0000_0400);
    rdr(3'd3, v); check("R4 entry 6 tid", v, 32'h0000_0011);
  endtask

  task automatic t_search;
    logic [31:0] v; int cyc; int c0;
    wr(3'd2, 32'h0000_0022);
    mdl_hit = 1'b0; mdl_delay = 3; c0 = lk_count;
    wr(3'd5, 32'hFFFF_F3FF);
    check("R5 lookup started", lk_count, c0 + 1);
    check("R5 lookup page number", {10'b0, seen_vpn}, 32'h003F_FFFC);
    rdr(3'd2, v); check("R5 miss sets bit 31", v, 32'h8000_0022);
    mdl_hit = 1'b1; mdl_idx = 8'd9; mdl_delay = 5;
    xfer(1'b1, 3'd5, 32'h0001_2C00, v, cyc);
    check("R9 ready held during lookup", cyc, 7);
    check("R5 hit page number", {10'b0, seen_vpn}, 32'h0000_004B);
    rdr(3'd2, v); check("R5 hit index", v, 32'h0000_0009);
    rdr(3'd5, v); check("R7 search offset reads 0", v, 32'h0);
  endtask

  task automatic t_level0;
    logic [31:0] v; int c0;
    acc_level = 2'd0;
    wr(3'd2, 32'h0000_0033);
    rdr(3'd2, v); check("R6 level0 read zero", v, 32'h0);
    c0 = lk_count;
    wr(3'd5, 32'h0000_0400);
    repeat (10) @(negedge clk);
    check("R6 level0 no lookup", lk_count, c0);
    acc_level = 2'd3;
    rdr(3'd2, v); check("R6 level0 write ignored", v, 32'h0000_0009);
  endtask

  task automatic t_read_gate;
    logic [31:0] v;
    wr(3'd4, 32'hA5A5_0F0F);
    acc_level = 2'd2;
    rdr(3'd3, v); check("R7 pid read gated", v, 32'h0);
    rdr(3'd4, v); check("R7 zone read gated", v, 32'h0);
    rdr(3'd1, v); check("R7 tag read gated", v, 32'h0);
    rdr(3'd2, v); check("R7 index readable", v, 32'h0000_0009);
    acc_level = 2'd3;
    rdr(3'd4, v); check("R7 zone read at level 3", v, 32'hA5A5_0F0F);
    rdr(3'd3, v); check("R7 gated tag read left pid", v, 32'h0000_0011);
  endtask

  task automatic t_write_gate;
    logic [31:0] v; int c0;
    acc_level = 2'd1;
    c0 = lk_count;
    wr(3'd3, 32'h0000_0077);
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h0000_0800);
    repeat (10) @(negedge clk);
    check("R8 search dropped at level 1", lk_count, c0);
    wr(3'd2, 32'd7);
    wr(3'd0, 32'h0000_BEEF);
    acc_level = 2'd3;
    rdr(3'd3, v); check("R8 pid write dropped", v, 32'h0000_0011);
    rdr(3'd4, v); check("R8 zone write dropped", v, 32'hA5A5_0F0F);
    rdr(3'd0, v); check("R8 window write allowed at level 1", v, 32'h0000_BEEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset;
    t_windows;
    t_index_select;
    t_search;
    t_level0;
    t_read_gate;
    t_write_gate;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule